// File: doc/BRIEF.md
# Grid-to-Warp Thread Index Generator

This block turns a one-dimensional kernel launch into a stream of warp descriptors. A launch is described only by an element count `n`. Threads are grouped into thread blocks of a fixed size (512 by default), so the launch covers ceil(n/512) blocks. Each block is split into warps of 32 consecutive threads, giving 16 warps per block. Every descriptor carries the block number, the warp number, the global index of each of the 32 lanes, and an active-lane mask. The mask clears every lane whose global index is `n` or larger, which handles a final block that is only partly filled.

Whole blocks go to a set of processing-cluster slots. When a new block is about to start, the block searches round-robin for a slot that is ready, starting one past the slot that took the previous block. Slots that are not ready at that moment are skipped. Once a slot holds a block, all 16 warps of that block go to it, in ascending warp order.

All slots share one descriptor bus. A one-hot `slot_valid` vector selects the destination, and each slot has its own `slot_ready`. Back-pressure rules for the bus:
- A descriptor moves only on a cycle where the selected slot's valid and ready are both high.
- While it waits for ready, the bus holds the descriptor unchanged and valid stays high.
- Valid never depends on the current cycle's ready.

Top module: `gw_grid_warp_gen`

## Requirements
- R1: A launch with count n delivers exactly 16 × ceil(n/512) descriptors, which is 16 for each block, including warps whose lanes are all inactive.
- R2: Blocks are delivered in ascending block number, starting at 0. Within a block, warps 0 to 15 are delivered in ascending order, one per accepted transfer. `desc_blk` and `desc_warp` carry these numbers.
- R3: Lane g of a descriptor carries global index `desc_blk`·512 + `desc_warp`·32 + g. It sits in bits [g·NW +: NW] of `desc_idx`.
- R4: Bit g of `desc_mask` is 1 exactly when lane g's global index is less than n. The active lanes therefore always form a contiguous run starting at lane 0.
- R5: At most one bit of `slot_valid` is high at a time. All 16 warps of a block go to the same slot.
- R6: The first block of a launch goes to the lowest-numbered ready slot. Each later block goes to the first ready slot found by searching upward, with wrap-around, from the slot after the one that took the previous block. A slot that is not ready is skipped.
- R7: While a descriptor is valid and its slot is not ready, `slot_valid` and all descriptor fields hold their values until the transfer happens.
- R8: A start with n = 0 produces no descriptor and raises `done` on the cycle after start.
- R9: `done` is low from the cycle after a start with n > 0 until the final descriptor has been accepted. It rises on the cycle after that acceptance and stays high, with no valid, until the next start.
- R10: `start` while a launch is in progress is ignored. `n_in` is captured only when an idle block accepts a start.
- R11: After reset, `slot_valid` and `done` are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse, honoured only when idle |
| n_in | input | NW | Element count of the launch |
| slot_ready | input | SLOTS | Per-slot ready |
| slot_valid | output | SLOTS | One-hot descriptor valid, selects the destination slot |
| desc_blk | output | NW-9 | Block number |
| desc_warp | output | 4 | Warp number within the block |
| desc_idx | output | 32·NW | Global index of every lane, lane g at [g·NW +: NW] |
| desc_mask | output | 32 | Active-lane mask |
| done | output | 1 | Launch finished |

## Verification
The bound properties make no assumption about how `slot_ready` behaves. A slot may drop ready at any point, including while holding a descriptor, and the hold and ordering properties must still apply. The index and mask properties rely on block size and warp width being powers of two. They also rely on global indices never passing 2^NW, which is always true because a count of at most 2^NW − 1 rounds up to at most 2^NW. The stimulus uses the following cases:
- A sweep of counts across several block boundaries under a pseudo-random ready pattern that frequently stalls the assigned slot.
- Fixed ready masks, which make the round-robin choice predictable.
- A start pulse injected partway through a launch, to show it is ignored.

// File: rtl/gw_pkg.sv
package gw_pkg;

  // Sequencer phases: waiting for a launch, choosing a slot for the next
  // block, presenting warps of the current block.
  typedef enum logic [1:0] {
    GW_IDLE   = 2'd0,
    GW_ASSIGN = 2'd1,
    GW_EMIT   = 2'd2
  } gw_state_e;

endpackage

// File: rtl/gw_slot_pick.sv
// Rotating search for the first ready slot at or after a start pointer.
module gw_slot_pick #(
  parameter int SLOTS = 4,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [SLOTS-1:0]  ready,
  input  logic [SLOT_W-1:0] from_ptr,
  output logic              found,
  output logic [SLOT_W-1:0] pick
);

  always_comb begin
    found = 1'b0;
    pick  = '0;
    // Walk the rotation from the far end so the nearest candidate wins.
    for (int k = SLOTS - 1; k >= 0; k--) begin
      if (ready[(int'(from_ptr) + k) % SLOTS]) begin
        found = 1'b1;
        pick  = SLOT_W'((int'(from_ptr) + k) % SLOTS);
      end
    end
  end

endmodule

// File: rtl/gw_lane_gen.sv
// Builds per-lane global indices from a warp base and compares each to n.
module gw_lane_gen #(
  parameter int NW    = 32,
  parameter int LANES = 32
) (
  input  logic [NW-1:0]       base,
  input  logic [NW-1:0]       n_lim,
  output logic [LANES*NW-1:0] idx_flat,
  output logic [LANES-1:0]    act_mask
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [NW-1:0] lane_idx;
    assign lane_idx               = base + NW'(g);
    assign idx_flat[g*NW +: NW]   = lane_idx;
    assign act_mask[g]            = (lane_idx < n_lim);
  end

endmodule

// File: rtl/gw_launch_ctrl.sv
// Launch sequencer: captures n, counts blocks and warps, owns the slot pointer.
module gw_launch_ctrl
  import gw_pkg::*;
#(
  parameter int NW            = 32,
  parameter int BLOCK_THREADS = 512,
  parameter int WARP_LANES    = 32,
  parameter int SLOTS         = 4,
  localparam int LOG_BLK  = $clog2(BLOCK_THREADS),
  localparam int LOG_LANE = $clog2(WARP_LANES),
  localparam int WARPS    = BLOCK_THREADS / WARP_LANES,
  localparam int WID_W    = (WARPS > 1) ? $clog2(WARPS) : 1,
  localparam int BID_W    = NW - LOG_BLK,
  localparam int BCNT_W   = BID_W + 1,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NW-1:0]     n_in,
  input  logic              pick_found,
  input  logic [SLOT_W-1:0] pick_slot,
  input  logic              accept,
  output logic              emit,
  output logic [BID_W-1:0]  blk_q,
  output logic [WID_W-1:0]  warp_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic [SLOT_W-1:0] rr_q,
  output logic [NW-1:0]     n_q,
  output logic              done_q
);

  gw_state_e         state_q;
  logic [BCNT_W-1:0] nblk_q;
  logic [NW:0]       n_round;
  logic [BCNT_W-1:0] nblk_in;
  logic              last_warp;
  logic              last_blk;
  logic [SLOT_W-1:0] rr_next;

  // Round up to whole blocks in one bit of headroom.
  assign n_round   = {1'b0, n_in} + (NW+1)'(BLOCK_THREADS - 1);
  assign nblk_in   = BCNT_W'(n_round >> LOG_BLK);
  assign last_warp = (warp_q == WID_W'(WARPS - 1));
  assign last_blk  = (({1'b0, blk_q} + BCNT_W'(1)) == nblk_q);
  assign rr_next   = (slot_q == SLOT_W'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
  assign emit      = (state_q == GW_EMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GW_IDLE;
      nblk_q  <= '0;
      n_q     <= '0;
      blk_q   <= '0;
      warp_q  <= '0;
      slot_q  <= '0;
      rr_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        GW_IDLE: begin
          if (start) begin
            n_q    <= n_in;
            nblk_q <= nblk_in;
            blk_q  <= '0;
            warp_q <= '0;
            rr_q   <= '0;
            done_q <= (n_in == '0);
            state_q <= (n_in == '0) ? GW_IDLE : GW_ASSIGN;
          end
        end
        GW_ASSIGN: begin
          if (pick_found) begin
            slot_q  <= pick_slot;
            warp_q  <= '0;
            state_q <= GW_EMIT;
          end
        end
        GW_EMIT: begin
          if (accept) begin
            if (!last_warp) begin
              warp_q <= warp_q + 1'b1;
            end else if (last_blk) begin
              done_q  <= 1'b1;
              state_q <= GW_IDLE;
            end else begin
              blk_q   <= blk_q + 1'b1;
              rr_q    <= rr_next;
              state_q <= GW_ASSIGN;
            end
          end
        end
        default: state_q <= GW_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gw_grid_warp_gen.sv
// Top: launch sequencer, slot chooser and lane index generator on one bus.
module gw_grid_warp_gen #(
  parameter int NW            = 32,
  parameter int BLOCK_THREADS = 512,
  parameter int WARP_LANES    = 32,
  parameter int SLOTS         = 4,
  localparam int LOG_BLK  = $clog2(BLOCK_THREADS),
  localparam int LOG_LANE = $clog2(WARP_LANES),
  localparam int WARPS    = BLOCK_THREADS / WARP_LANES,
  localparam int WID_W    = (WARPS > 1) ? $clog2(WARPS) : 1,
  localparam int BID_W    = NW - LOG_BLK,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [NW-1:0]            n_in,
  input  logic [SLOTS-1:0]         slot_ready,
  output logic [SLOTS-1:0]         slot_valid,
  output logic [BID_W-1:0]         desc_blk,
  output logic [WID_W-1:0]         desc_warp,
  output logic [WARP_LANES*NW-1:0] desc_idx,
  output logic [WARP_LANES-1:0]    desc_mask,
  output logic                     done
);

  logic              emit;
  logic [BID_W-1:0]  blk_q;
  logic [WID_W-1:0]  warp_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] rr_q;
  logic [NW-1:0]     n_q;
  logic              pick_found;
  logic [SLOT_W-1:0] pick_slot;
  logic              accept;
  logic [NW-1:0]     warp_base;

  gw_launch_ctrl #(
    .NW(NW), .BLOCK_THREADS(BLOCK_THREADS),
    .WARP_LANES(WARP_LANES), .SLOTS(SLOTS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .n_in(n_in),
    .pick_found(pick_found), .pick_slot(pick_slot), .accept(accept),
    .emit(emit), .blk_q(blk_q), .warp_q(warp_q), .slot_q(slot_q),
    .rr_q(rr_q), .n_q(n_q), .done_q(done)
  );

  gw_slot_pick #(.SLOTS(SLOTS)) u_pick (
    .ready(slot_ready), .from_ptr(rr_q),
    .found(pick_found), .pick(pick_slot)
  );

  // Block and warp numbers concatenate into the lane-0 index (power-of-two sizes).
  assign warp_base = {blk_q, warp_q, {LOG_LANE{1'b0}}};

  gw_lane_gen #(.NW(NW), .LANES(WARP_LANES)) u_lanes (
    .base(warp_base), .n_lim(n_q),
    .idx_flat(desc_idx), .act_mask(desc_mask)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_valid
    assign slot_valid[s] = emit && (slot_q == SLOT_W'(s));
  end

  assign accept    = |(slot_valid & slot_ready);
  assign desc_blk  = blk_q;
  assign desc_warp = warp_q;

endmodule

// File: rtl/gw_grid_warp_gen_chk.sv
module gw_grid_warp_gen_chk #(
  parameter int NW            = 32,
  parameter int BLOCK_THREADS = 512,
  parameter int WARP_LANES    = 32,
  parameter int SLOTS         = 4,
  localparam int LOG_BLK  = $clog2(BLOCK_THREADS),
  localparam int LOG_LANE = $clog2(WARP_LANES),
  localparam int WARPS    = BLOCK_THREADS / WARP_LANES,
  localparam int WID_W    = (WARPS > 1) ? $clog2(WARPS) : 1,
  localparam int BID_W    = NW - LOG_BLK
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [SLOTS-1:0]         slot_valid,
  input logic [SLOTS-1:0]         slot_ready,
  input logic [BID_W-1:0]         desc_blk,
  input logic [WID_W-1:0]         desc_warp,
  input logic [WARP_LANES*NW-1:0] desc_idx,
  input logic [WARP_LANES-1:0]    desc_mask,
  input logic                     done
);

  logic xfer;
  logic stall;
  assign xfer  = |(slot_valid & slot_ready);
  assign stall = |(slot_valid & ~slot_ready);

  // R5
  valid_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_valid));

  // R7
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (slot_valid == $past(slot_valid)) && $stable(desc_blk)
              && $stable(desc_warp) && $stable(desc_mask) && $stable(desc_idx));

  // R2
  warp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && desc_warp != WID_W'(WARPS - 1)) |=>
      (slot_valid == $past(slot_valid)) && $stable(desc_blk)
      && (desc_warp == WID_W'($past(desc_warp) + 1'b1)));

  // R3
  lane_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_valid) |-> (desc_idx[(WARP_LANES-1)*NW +: NW]
                       == desc_idx[0 +: NW] + NW'(WARP_LANES - 1))
                      && (desc_idx[LOG_LANE-1:0] == '0));

  // R4
  mask_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_valid) |-> ((desc_mask & (desc_mask + 1'b1)) == '0));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (slot_valid == '0));

endmodule

bind gw_grid_warp_gen gw_grid_warp_gen_chk #(
  .NW(NW), .BLOCK_THREADS(BLOCK_THREADS),
  .WARP_LANES(WARP_LANES), .SLOTS(SLOTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_ready(slot_ready),
  .desc_blk(desc_blk), .desc_warp(desc_warp), .desc_idx(desc_idx),
  .desc_mask(desc_mask), .done(done)
);

// File: tb/tb_gw_grid_warp_gen.sv
module tb_gw_grid_warp_gen;

  localparam int NW = 32;
  localparam int BT = 512;
  localparam int LN = 32;
  localparam int SL = 4;
  localparam int WPB = BT / LN;
  localparam int BIDW = NW - 9;
  localparam int WIDW = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [NW-1:0]     n_in;
  logic [SL-1:0]     slot_ready;
  logic [SL-1:0]     slot_valid;
  logic [BIDW-1:0]   desc_blk;
  logic [WIDW-1:0]   desc_warp;
  logic [LN*NW-1:0]  desc_idx;
  logic [LN-1:0]     desc_mask;
  logic              done;

  int checks = 0;
  int failures = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  gw_grid_warp_gen #(.NW(NW), .BLOCK_THREADS(BT), .WARP_LANES(LN), .SLOTS(SL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .n_in(n_in),
    .slot_ready(slot_ready), .slot_valid(slot_valid), .desc_blk(desc_blk),
    .desc_warp(desc_warp), .desc_idx(desc_idx), .desc_mask(desc_mask), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // mode 0: fixed ready mask smask; mode 1: pseudo-random ready.
  task automatic run_launch(input longint n, input int mode,
                            input logic [SL-1:0] smask, input int inject_at);
    longint blocks = (n + BT - 1) / BT;
    longint eb = 0;
    int ew = 0;
    int cur_slot = -1;
    int rr = 0;
    int cyc = 0;
    bit last_acc = 0;
    bit stalled = 0;
    logic [SL-1:0]   sv = '0;
    logic [BIDW-1:0] sb = '0;
    logic [WIDW-1:0] sw = '0;
    logic [LN-1:0]   sm = '0;

    @(negedge clk);
    start = 1'b1;
    n_in  = NW'(n);
    @(negedge clk);
    start = 1'b0;
    n_in  = ~NW'(n);   // changing n after start must not matter (R10)

    if (n == 0) begin
      chk(done == 1'b1, "R8", "done after zero-count start", done, 1);
      slot_ready = '1;
      for (int i = 0; i < 4; i++) begin
        chk(slot_valid == '0, "R8", "no descriptor for n=0", slot_valid, 0);
        @(negedge clk);
      end
      return;
    end

    forever begin
      if (last_acc) begin
        chk(done == 1'b1, "R9", "done the cycle after final accept", done, 1);
        break;
      end
      if (done) begin
        chk(1'b0, "R9", "done before final descriptor", eb * WPB + ew, blocks * WPB);
        break;
      end
      cyc++;
      if (cyc > 4000) begin
        chk(1'b0, "R1", "launch stuck", eb * WPB + ew, blocks * WPB);
        break;
      end
      if (stalled) begin
        chk(slot_valid == sv && desc_blk == sb && desc_warp == sw && desc_mask == sm,
            "R7", "descriptor held while stalled", desc_warp, sw);
        stalled = 0;
      end
      if (cyc == inject_at) begin
        start = 1'b1;
        n_in  = NW'(5);
      end else begin
        start = 1'b0;
      end
      slot_ready = (mode == 0) ? smask : lfsr[SL-1:0];
      chk($countones(slot_valid) <= 1, "R5", "valid one-hot", slot_valid, 1);

      if ((slot_valid & slot_ready) != '0) begin
        int s = 0;
        bit lane_bad = 0;
        longint bad_act = 0;
        longint bad_exp = 0;
        for (int i = 0; i < SL; i++) if (slot_valid[i]) s = i;
        chk(longint'(desc_blk) == eb, "R2", "block number", desc_blk, eb);
        chk(int'(desc_warp) == ew, "R2", "warp number", desc_warp, ew);
        for (int g = 0; g < LN; g++) begin
          longint gi = eb * BT + ew * LN + g;
          longint ai = longint'(desc_idx[g*NW +: NW]);
          if (!lane_bad && ai != gi) begin
            lane_bad = 1; bad_act = ai; bad_exp = gi;
          end
        end
        chk(!lane_bad, "R3", "lane global index", bad_act, bad_exp);
        lane_bad = 0;
        for (int g = 0; g < LN; g++) begin
          longint gi = eb * BT + ew * LN + g;
          if (!lane_bad && desc_mask[g] != (gi < n)) begin
            lane_bad = 1; bad_act = desc_mask[g]; bad_exp = (gi < n);
          end
        end
        chk(!lane_bad, "R4", "active-lane mask bit", bad_act, bad_exp);
        if (ew == 0) begin
          if (mode == 0) begin
            int es = -1;
            for (int k = SL - 1; k >= 0; k--)
              if (smask[(rr + k) % SL]) es = (rr + k) % SL;
            chk(s == es, "R6", "round-robin slot for new block", s, es);
          end
          cur_slot = s;
        end else begin
          chk(s == cur_slot, "R5", "block stays on one slot", s, cur_slot);
        end
        ew++;
        if (ew == WPB) begin
          ew = 0;
          eb++;
          rr = (s + 1) % SL;
          if (eb == blocks) last_acc = 1;
        end
      end else if (slot_valid != '0) begin
        stalled = 1;
        sv = slot_valid; sb = desc_blk; sw = desc_warp; sm = desc_mask;
      end
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    start = 1'b0;
    chk(eb * WPB + ew == blocks * WPB, "R1", "descriptor count", eb * WPB + ew, blocks * WPB);
    slot_ready = '1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(done == 1'b1 && slot_valid == '0, "R9", "done holds, no valid", done, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    n_in = '0;
    slot_ready = '0;
    repeat (3) @(negedge clk);
    chk(slot_valid == '0 && done == 1'b0, "R11", "reset outputs", {slot_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(slot_valid == '0 && done == 1'b0, "R11", "idle after reset", {slot_valid, done}, 0);

    // R8: zero count, twice (also after a finished launch)
    run_launch(0, 1, '1, 0);
    // R1..R4, R7: sweep across block boundaries under random ready
    for (int n = 1; n <= 1100; n += 7) run_launch(n, 1, '0, 0);
    begin
      int edges[13] = '{1, 31, 32, 33, 511, 512, 513, 1023, 1024, 1025, 2047, 2048, 2049};
      foreach (edges[i]) run_launch(edges[i], 1, '0, 0);
    end
    run_launch(0, 0, 4'b1111, 0);
    // R6: fixed masks make the round-robin choice predictable
    run_launch(2600, 0, 4'b1111, 0);
    run_launch(2600, 0, 4'b1010, 0);
    run_launch(2600, 0, 4'b0100, 0);
    run_launch(2600, 0, 4'b1001, 0);
    // R10: start pulse during a launch is ignored
    run_launch(1500, 0, 4'b0110, 9);
    run_launch(1500, 1, '0, 20);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule